// File: doc/BRIEF.md
# Indexed card register window with interrupt summary

This block decodes a 32-byte card I/O space. The low part of the space holds a small set of card-level registers: a combined status/control byte, a configuration byte and an index byte. The upper sixteen bytes form a shared data window. The window does not pick its target from address bits. Software first writes a code into the index byte. That code maps the window onto one of the attached units: either of two HDLC channel register files, the FIFO of the line interface, or one of two line-interface register banks. Software reaches a line-interface register above 0x2F through the high bank and every other line-interface register through the low bank. In both cases the low four address bits pick the register.

The attached units are modelled as stubs: a 16-byte register file for each bank and a small first-in first-out store. The status byte collects active-low interrupt requests from the line interface, from the HDLC pair (the OR of both channels) and from an internal periodic timer. When all three read as one, the card has no request pending. The control half of the same byte holds the attached units in reset, freezes or clears the timer, and gates the interrupt output. Writing zero there shuts the card's interrupt down.

Top module: `card_window_ctl`

## Requirements
- R1: While and just after `rst_i` is high, `bus_rdata_o`, `irq_o`, `irq_sel_o`, `serial_en_o` and `unit_rst_o` are all zero. The index byte and the configuration byte read as zero.
- R2: Offset 0x04 holds the index byte. A write stores all 8 bits and a read returns them unchanged.
- R3: The window occupies offsets 0x10 to 0x1F, and address bits 3:0 select one of 16 byte registers. Index code 0x00 maps the window to HDLC channel 1, 0x01 to HDLC channel 2, 0x04 to the low line-interface bank and 0x06 to the high bank. Each is a separate store, so data written under one code cannot be seen under another.
- R4: Index code 0x02 maps the whole window to the line-interface FIFO (8 entries by default). A window write pushes a byte and a window read pops bytes in write order. A read of an empty FIFO returns 0x00, and a write to a full FIFO is dropped.
- R5: Under any other index code, window writes change no store and window reads return 0x00.
- R6: Reading offset 0x02 returns bit 0 = NOT line-interface request, bit 1 = NOT (HDLC channel 1 request OR channel 2 request), bit 2 = NOT timer request, and bits 7:3 = 0.
- R7: Control bits written to offset 0x02 are bit 0 unit reset, bit 1 timer hold, bit 2 timer clear (one-shot) and bit 3 interrupt enable. On each clock, `irq_o` takes the value (enable AND any request) of the preceding cycle.
- R8: While the hold bit is clear, the timer raises its request after TIMER_PERIOD counting cycles, and the request stays raised. Setting the hold bit freezes the count but keeps the request. A write with bit 2 set clears both the count and the request.
- R9: While control bit 0 is set, `unit_rst_o` is high. Every bank and the FIFO are cleared, and window writes are ignored. Data written before the reset reads back as 0x00 after the reset is released.
- R10: Offset 0x03 stores bits 3:0 (driven on `irq_sel_o`) and bit 7 (driven on `serial_en_o`). A read returns these bits with bits 6:4 as zero.
- R11: Writing 0x00 to offset 0x02 forces `irq_o` low from the second clock after the write, whatever requests are pending.
- R12: Read data appears on `bus_rdata_o` one clock after the read strobe and is 0x00 on every other cycle. Offsets that hold no register read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W | Byte offset inside the card space |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data, zero when no read |
| li_req_i | input | 1 | Line-interface interrupt request, active high |
| hdlc_req_i | input | 2 | HDLC channel 2/1 interrupt requests, active high |
| irq_o | output | 1 | Registered card interrupt output |
| irq_sel_o | output | 4 | Interrupt-line select from the configuration byte |
| serial_en_o | output | 1 | Serial line-interface bus enable |
| unit_rst_o | output | 1 | Reset hold for the attached units |

## Verification
The bench walks every index code, both the mapped and the unmapped ones, over the same window offsets. This shows that each store is separate and that an unmapped code neither writes nor leaks data. The FIFO test pushes past capacity and then pops past empty, which separates drop-on-full and zero-on-empty from plain ordering. Each request source is then raised on its own, both HDLC channels are raised together, and all sources are dropped at the end. This separates each active-low status bit and the enable gating of the interrupt. A timer run, a hold and a clear check the sticky request. A unit-reset pass shows that stored data is erased and that writes made during the reset are lost.

// File: rtl/card_window_pkg.sv
package card_window_pkg;
  localparam int BYTE_W    = 8;
  localparam int REG_AW    = 4;
  localparam int NUM_BANKS = 4;
  localparam int NUM_HDLC  = 2;

  localparam int OFS_STAT = 2;
  localparam int OFS_CFG  = 3;
  localparam int OFS_IDX  = 4;

  localparam int CTL_RST  = 0;
  localparam int CTL_TDIS = 1;
  localparam int CTL_TCLR = 2;
  localparam int CTL_IEN  = 3;

  localparam logic [BYTE_W-1:0] CFG_KEEP_MASK = 8'h8F;

  typedef enum logic [2:0] {
    TGT_CH1  = 3'd0,
    TGT_CH2  = 3'd1,
    TGT_LOW  = 3'd2,
    TGT_HIGH = 3'd3,
    TGT_FIFO = 3'd4,
    TGT_NONE = 3'd7
  } win_tgt_e;

  function automatic win_tgt_e decode_index(input logic [BYTE_W-1:0] code);
    case (code)
      8'h00:   return TGT_CH1;
      8'h01:   return TGT_CH2;
      8'h02:   return TGT_FIFO;
      8'h04:   return TGT_LOW;
      8'h06:   return TGT_HIGH;
      default: return TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/card_window_bank.sv
module card_window_bank #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/card_window_fifo.sv
module card_window_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != CW'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wrap_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= wrap_inc(rd_ptr_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/card_window_timer.sv
module card_window_timer #(
  parameter int PERIOD = 1000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clear_i,
  input  logic hold_i,
  output logic req_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) begin
      cnt_q <= '0;
      req_o <= 1'b0;
    end else if (!hold_i) begin
      if (cnt_q == CW'(PERIOD - 1)) begin
        cnt_q <= '0;
        req_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/card_window_ctl.sv
module card_window_ctl
  import card_window_pkg::*;
#(
  parameter int ADDR_W       = 5,
  parameter int FIFO_DEPTH   = 8,
  parameter int TIMER_PERIOD = 1000
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_wr_i,
  input  logic                bus_rd_i,
  input  logic [BYTE_W-1:0]   bus_wdata_i,
  output logic [BYTE_W-1:0]   bus_rdata_o,
  input  logic                li_req_i,
  input  logic [NUM_HDLC-1:0] hdlc_req_i,
  output logic                irq_o,
  output logic [3:0]          irq_sel_o,
  output logic                serial_en_o,
  output logic                unit_rst_o
);
  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(16);

  logic [3:0]        ctrl_q;
  logic [BYTE_W-1:0] cfg_q, idx_q, rd_next;
  win_tgt_e          tgt;
  logic [2:0]        tgt_code;
  logic              win_hit, card_rst, unit_clr, win_wr;
  logic              wr_stat, wr_cfg, wr_idx, timer_clr, timer_req;
  logic              fifo_push, fifo_pop, fifo_empty, any_req;
  logic [REG_AW-1:0] reg_sel;
  logic [BYTE_W-1:0] bank_rd [NUM_BANKS];
  logic [BYTE_W-1:0] fifo_rd, status_byte;
  logic              unused_ctrl;

  assign tgt      = decode_index(idx_q);
  assign tgt_code = tgt;
  assign win_hit  = bus_addr_i[ADDR_W-1:REG_AW] == WIN_BASE[ADDR_W-1:REG_AW];
  assign reg_sel  = bus_addr_i[REG_AW-1:0];
  assign card_rst = ctrl_q[CTL_RST];
  assign unit_clr = rst_i || card_rst;
  assign win_wr   = bus_wr_i && win_hit && !card_rst;

  assign wr_stat   = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_STAT));
  assign wr_cfg    = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_CFG));
  assign wr_idx    = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_IDX));
  assign timer_clr = wr_stat && bus_wdata_i[CTL_TCLR];

  assign fifo_push = win_wr && (tgt == TGT_FIFO);
  assign fifo_pop  = bus_rd_i && win_hit && (tgt == TGT_FIFO);

  card_window_timer #(.PERIOD(TIMER_PERIOD)) u_timer (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .clear_i (timer_clr),
    .hold_i  (ctrl_q[CTL_TDIS]),
    .req_o   (timer_req)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    card_window_bank #(.DW(BYTE_W), .AW(REG_AW)) u_bank (
      .clk_i   (clk_i),
      .clr_i   (unit_clr),
      .we_i    (win_wr && (tgt_code == 3'(g))),
      .addr_i  (reg_sel),
      .wdata_i (bus_wdata_i),
      .rdata_o (bank_rd[g])
    );
  end

  card_window_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .clr_i   (unit_clr),
    .push_i  (fifo_push),
    .pop_i   (fifo_pop),
    .wdata_i (bus_wdata_i),
    .rdata_o (fifo_rd),
    .empty_o (fifo_empty)
  );

  assign any_req     = li_req_i || (|hdlc_req_i) || timer_req;
  assign status_byte = {5'b0, ~timer_req, ~(|hdlc_req_i), ~li_req_i};

  always_comb begin
    rd_next = '0;
    if (win_hit) begin
      case (tgt)
        TGT_CH1, TGT_CH2, TGT_LOW, TGT_HIGH: rd_next = bank_rd[tgt_code[1:0]];
        TGT_FIFO: rd_next = fifo_empty ? '0 : fifo_rd;
        default:  rd_next = '0;
      endcase
    end else if (bus_addr_i == ADDR_W'(OFS_STAT)) begin
      rd_next = status_byte;
    end else if (bus_addr_i == ADDR_W'(OFS_CFG)) begin
      rd_next = cfg_q;
    end else if (bus_addr_i == ADDR_W'(OFS_IDX)) begin
      rd_next = idx_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q      <= '0;
      cfg_q       <= '0;
      idx_q       <= '0;
      bus_rdata_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      bus_rdata_o <= bus_rd_i ? rd_next : '0;
      irq_o       <= ctrl_q[CTL_IEN] && any_req;
      if (wr_stat) ctrl_q <= bus_wdata_i[3:0];
      if (wr_cfg)  cfg_q  <= bus_wdata_i & CFG_KEEP_MASK;
      if (wr_idx)  idx_q  <= bus_wdata_i;
    end
  end

  assign irq_sel_o   = cfg_q[3:0];
  assign serial_en_o = cfg_q[7];
  assign unit_rst_o  = card_rst;
  assign unused_ctrl = ctrl_q[CTL_TCLR];
endmodule

// File: rtl/card_window_ctl_chk.sv
module card_window_ctl_chk
  import card_window_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [BYTE_W-1:0] bus_wdata_i,
  input logic [BYTE_W-1:0] bus_rdata_o,
  input logic              irq_o,
  input logic [3:0]        ctrl_q,
  input logic              timer_req,
  input logic              fifo_empty,
  input logic              unit_rst_o
);
  assert_idle_bus_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    !bus_rd_i |=> (bus_rdata_o == '0));

  assert_status_pad_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_rd_i && bus_addr_i == ADDR_W'(OFS_STAT)) |=> (bus_rdata_o[7:3] == '0));

  assert_cfg_pad_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_rd_i && bus_addr_i == ADDR_W'(OFS_CFG)) |=> (bus_rdata_o[6:4] == '0));

  assert_irq_gated_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !ctrl_q[CTL_IEN] |=> !irq_o);

  assert_shutdown_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_wr_i && bus_addr_i == ADDR_W'(OFS_STAT) && bus_wdata_i == '0) |=> ##1 !irq_o);

  assert_timer_clear_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_wr_i && bus_addr_i == ADDR_W'(OFS_STAT) && bus_wdata_i[CTL_TCLR]) |=> !timer_req);

  assert_unit_reset_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    unit_rst_o |=> fifo_empty);
endmodule

bind card_window_ctl card_window_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .ctrl_q      (ctrl_q),
  .timer_req   (timer_req),
  .fifo_empty  (fifo_empty),
  .unit_rst_o  (unit_rst_o)
);

// File: tb/card_window_ctl_tb_top.sv
module card_window_ctl_tb_top;
  localparam int AW = 5;
  localparam int FD = 8;
  localparam int TP = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          li = 1'b0;
  logic [1:0]    hreq = 2'b00;
  logic          irq, serial_en, unit_rst;
  logic [3:0]    irq_sel;

  int    vectors = 0;
  int    miscompares = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  card_window_ctl #(.ADDR_W(AW), .FIFO_DEPTH(FD), .TIMER_PERIOD(TP)) dut_i (
    .clk_i(clk), .rst_i(rst), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .li_req_i(li), .hdlc_req_i(hreq),
    .irq_o(irq), .irq_sel_o(irq_sel), .serial_en_o(serial_en), .unit_rst_o(unit_rst)
  );

  // Behavioural reference model
  logic [3:0] m_ctrl;
  logic [7:0] m_cfg, m_idx, m_rdata;
  logic       m_irq, m_treq, m_nirq;
  logic [7:0] m_bank [4][16];
  logic [7:0] m_q [$];
  logic [7:0] m_rv;
  int         m_cnt, m_tg;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = '0; m_cfg = '0; m_idx = '0; m_rdata = '0; m_irq = 1'b0;
      m_treq = 1'b0; m_cnt = 0; m_q.delete();
      for (int b = 0; b < 4; b++) for (int r = 0; r < 16; r++) m_bank[b][r] = '0;
    end else begin
      case (m_idx)
        8'h00: m_tg = 0;
        8'h01: m_tg = 1;
        8'h04: m_tg = 2;
        8'h06: m_tg = 3;
        8'h02: m_tg = 4;
        default: m_tg = 5;
      endcase
      m_rv = '0;
      if (addr >= 16) begin
        if (m_tg < 4) m_rv = m_bank[m_tg][addr[3:0]];
        else if (m_tg == 4 && m_q.size() > 0) m_rv = m_q[0];
      end else if (addr == 2) m_rv = {5'b0, ~m_treq, ~(hreq[0] | hreq[1]), ~li};
      else if (addr == 3) m_rv = m_cfg;
      else if (addr == 4) m_rv = m_idx;
      m_nirq = m_ctrl[3] & (li | hreq[0] | hreq[1] | m_treq);
      if (wr && addr == 2 && wdata[2]) begin
        m_cnt = 0; m_treq = 1'b0;
      end else if (!m_ctrl[1]) begin
        if (m_cnt == TP - 1) begin m_cnt = 0; m_treq = 1'b1; end
        else m_cnt = m_cnt + 1;
      end
      if (m_ctrl[0]) begin
        m_q.delete();
        for (int b = 0; b < 4; b++) for (int r = 0; r < 16; r++) m_bank[b][r] = '0;
      end else begin
        if (wr && addr >= 16) begin
          if (m_tg < 4) m_bank[m_tg][addr[3:0]] = wdata;
          else if (m_tg == 4 && m_q.size() < FD) m_q.push_back(wdata);
        end
        if (rd && addr >= 16 && m_tg == 4 && m_q.size() > 0) void'(m_q.pop_front());
      end
      if (wr && addr == 2) m_ctrl = wdata[3:0];
      if (wr && addr == 3) m_cfg = wdata & 8'h8F;
      if (wr && addr == 4) m_idx = wdata;
      m_rdata = rd ? m_rv : '0;
      m_irq = m_nirq;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (rdata !== m_rdata || irq !== m_irq || irq_sel !== m_cfg[3:0] ||
          serial_en !== m_cfg[7] || unit_rst !== m_ctrl[0]) begin
        miscompares++;
        $display("FAIL %s model: actual rdata=%02h irq=%b sel=%h ser=%b urst=%b expected rdata=%02h irq=%b sel=%h ser=%b urst=%b",
                 phase, rdata, irq, irq_sel, serial_en, unit_rst,
                 m_rdata, m_irq, m_cfg[3:0], m_cfg[7], m_ctrl[0]);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic expect_read(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; got = rdata;
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s read @%02h: actual %02h expected %02h", tag, a, got, exp);
    end
  endtask

  task automatic expect_bit(input logic got, input logic exp, input string tag);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  bit finished = 0;

  initial begin
    #(200000 * 4);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle(3);
    phase = "R1";
    expect_bit(rdata == 8'h00, 1'b1, "R1 rdata in reset");
    expect_bit(irq, 1'b0, "R1 irq in reset");
    expect_bit(unit_rst, 1'b0, "R1 unit_rst in reset");
    expect_bit(serial_en | (|irq_sel), 1'b0, "R1 config outputs in reset");
    @(negedge clk); rst = 1'b0;
    expect_read(5'h04, 8'h00, "R1 index after reset");
    expect_read(5'h03, 8'h00, "R1 config after reset");

    phase = "R2";
    bus_write(5'h04, 8'hA5);
    expect_read(5'h04, 8'hA5, "R2 index readback");

    phase = "R3";
    bus_write(5'h04, 8'h00); bus_write(5'h13, 8'h11);
    bus_write(5'h04, 8'h01); bus_write(5'h13, 8'h22);
    bus_write(5'h04, 8'h04); bus_write(5'h13, 8'h33);
    bus_write(5'h04, 8'h06); bus_write(5'h13, 8'h44); bus_write(5'h1F, 8'h77);
    expect_read(5'h1F, 8'h77, "R3 high bank top register");
    expect_read(5'h13, 8'h44, "R3 high bank");
    bus_write(5'h04, 8'h00);
    expect_read(5'h13, 8'h11, "R3 HDLC channel 1");
    expect_read(5'h14, 8'h00, "R3 untouched register");
    expect_read(5'h1F, 8'h00, "R3 channel 1 isolated from high bank");
    bus_write(5'h04, 8'h01);
    expect_read(5'h13, 8'h22, "R3 HDLC channel 2");
    bus_write(5'h04, 8'h04);
    expect_read(5'h13, 8'h33, "R3 low bank");

    phase = "R5";
    bus_write(5'h04, 8'h03); bus_write(5'h13, 8'hEE);
    expect_read(5'h13, 8'h00, "R5 unmapped code reads zero");
    bus_write(5'h04, 8'h07); bus_write(5'h18, 8'hEE);
    expect_read(5'h18, 8'h00, "R5 unmapped code 0x07");
    bus_write(5'h04, 8'h00);
    expect_read(5'h13, 8'h11, "R5 channel 1 unchanged");
    bus_write(5'h04, 8'h06);
    expect_read(5'h13, 8'h44, "R5 high bank unchanged");

    phase = "R4";
    bus_write(5'h04, 8'h02);
    expect_read(5'h10, 8'h00, "R4 empty FIFO");
    for (int i = 0; i < 10; i++) bus_write(5'h10 + 5'(i), 8'h80 + 8'(i));
    for (int i = 0; i < 8; i++) expect_read(5'h1A, 8'h80 + 8'(i), "R4 FIFO order");
    expect_read(5'h10, 8'h00, "R4 overflow dropped, FIFO empty");

    phase = "R6";
    bus_write(5'h02, 8'h06);
    @(negedge clk); li = 1'b1;
    expect_read(5'h02, 8'h06, "R6 line-interface request");
    @(negedge clk); li = 1'b0; hreq = 2'b10;
    expect_read(5'h02, 8'h05, "R6 HDLC channel 2 request");
    @(negedge clk); hreq = 2'b01;
    expect_read(5'h02, 8'h05, "R6 HDLC channel 1 request");
    @(negedge clk); hreq = 2'b11;
    expect_read(5'h02, 8'h05, "R6 both HDLC requests");
    @(negedge clk); hreq = 2'b00;
    expect_read(5'h02, 8'h07, "R6 no request");

    phase = "R7";
    @(negedge clk); li = 1'b1;
    idle(2);
    expect_bit(irq, 1'b0, "R7 request without enable");
    bus_write(5'h02, 8'h0A);
    idle(2);
    expect_bit(irq, 1'b1, "R7 enabled line-interface request");
    @(negedge clk); li = 1'b0;
    idle(2);
    expect_bit(irq, 1'b0, "R7 no request");
    @(negedge clk); hreq = 2'b01;
    idle(2);
    expect_bit(irq, 1'b1, "R7 HDLC request");

    phase = "R11";
    bus_write(5'h02, 8'h00);
    idle(1);
    expect_bit(irq, 1'b0, "R11 shutdown with pending request");
    @(negedge clk); hreq = 2'b00;

    phase = "R8";
    bus_write(5'h02, 8'h04);
    idle(TP / 2);
    expect_read(5'h02, 8'h07, "R8 timer not yet expired");
    idle(TP);
    expect_read(5'h02, 8'h03, "R8 timer expired");
    bus_write(5'h02, 8'h02);
    idle(TP);
    expect_read(5'h02, 8'h03, "R8 hold keeps request");
    bus_write(5'h02, 8'h0E);
    idle(2 * TP);
    expect_read(5'h02, 8'h07, "R8 clear with hold");
    expect_bit(irq, 1'b0, "R8 no irq after clear");
    bus_write(5'h02, 8'h08);
    idle(TP + 4);
    expect_bit(irq, 1'b1, "R8 timer raises irq");

    phase = "R9";
    bus_write(5'h02, 8'h02);
    bus_write(5'h04, 8'h00); bus_write(5'h15, 8'h99);
    bus_write(5'h04, 8'h02); bus_write(5'h10, 8'h55);
    bus_write(5'h02, 8'h03);
    idle(1);
    expect_bit(unit_rst, 1'b1, "R9 unit reset output");
    bus_write(5'h04, 8'h00); bus_write(5'h15, 8'h66);
    expect_read(5'h15, 8'h00, "R9 write ignored in reset");
    bus_write(5'h02, 8'h02);
    expect_bit(unit_rst, 1'b0, "R9 unit reset released");
    expect_read(5'h15, 8'h00, "R9 channel 1 cleared");
    bus_write(5'h04, 8'h06);
    expect_read(5'h13, 8'h00, "R9 high bank cleared");
    bus_write(5'h04, 8'h02);
    expect_read(5'h10, 8'h00, "R9 FIFO cleared");

    phase = "R10";
    bus_write(5'h03, 8'hFF);
    expect_bit(irq_sel == 4'hF && serial_en, 1'b1, "R10 config outputs set");
    expect_read(5'h03, 8'h8F, "R10 config readback");
    bus_write(5'h03, 8'h35);
    expect_bit(irq_sel == 4'h5 && !serial_en, 1'b1, "R10 config outputs changed");
    expect_read(5'h03, 8'h05, "R10 config readback 2");

    phase = "R12";
    expect_read(5'h00, 8'h00, "R12 offset 0x00");
    expect_read(5'h07, 8'h00, "R12 offset 0x07");
    expect_read(5'h0F, 8'h00, "R12 offset 0x0F");
    idle(3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule